// File: doc/BRIEF.md
# High-Byte Extension Prefix Unit

This block lets a narrow core build 16-bit operands from 8-bit immediates. Software first writes a byte into a holding register (the extension byte). That write arms a one-shot flag. The next instruction the core issues uses the armed state and then disarms the flag, whether or not that instruction can use it. The extension byte itself stays in place afterwards and changes only on the next write or on reset.

Three instruction classes use the extension:
- **Index low-byte load.** The extension byte is placed above the immediate, and the whole 16-bit index value is replaced.
- **Index addition.** The combined 16-bit value is added to the full index register.
- **Relative jump.** The combined value is used as a 16-bit offset from the program counter, with a bias of one.

When the flag is not armed, these classes fall back to their narrow forms:
- the load replaces only the low byte;
- the addition and the jump use the immediate sign-extended from 8 bits.

The core supplies the base value: the current index register for the two index classes, or the current program counter for the jump. The block returns a registered result one clock after the issue. Decoding the instruction is left to the core.

Top module: `ext_prefix_unit`

## Requirements
- R1: While reset is high, and in the first cycle after it, `ext_byte`, `ext_armed`, `res_valid` and `res_value` are all zero.
- R2: A cycle with `ext_wr` high stores `ext_wdata` in `ext_byte` and sets `ext_armed`. Both are visible after that clock edge.
- R3: `ext_byte` changes only on a write. Issuing any instruction, armed or not, leaves it unchanged.
- R4: A cycle with `issue` high and `ext_wr` low clears `ext_armed` after the edge, for every class including class 0 (plain). A later eligible issue therefore takes the unextended form.
- R5: Class 1 (index low-byte load) returns `{ext_byte, imm}` when armed. When not armed it returns `{op_base[15:8], imm}`.
- R6: Class 2 (index addition) returns `op_base + {ext_byte, imm}` modulo 2^16 when armed. When not armed it returns `op_base` plus `imm` sign-extended, modulo 2^16.
- R7: Class 3 (relative jump) returns `op_base + {ext_byte, imm} + 1` modulo 2^16 when armed. When not armed it returns `op_base` plus `imm` sign-extended plus 1, modulo 2^16.
- R8: Class 0 (plain, code 2'b00) produces no result: `res_valid` stays low and `res_value` keeps its previous value.
- R9: When `ext_wr` and `issue` are high in the same cycle, the issued instruction uses the byte and flag as they were before that edge. After the edge, the new byte is held and the flag is armed.
- R10: `res_valid` is high for exactly the one cycle after each issue of class 1, 2 or 3. `res_value` holds its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_wr | input | 1 | Write strobe for the extension byte |
| ext_wdata | input | 8 | Byte to store in the extension register |
| issue | input | 1 | Instruction issue strobe |
| issue_cls | input | 2 | Class: 0 plain, 1 index low load, 2 index add, 3 relative jump |
| imm | input | 8 | Immediate carried by the issued instruction |
| op_base | input | 16 | Current index register (classes 1, 2) or program counter (class 3) |
| ext_byte | output | 8 | Extension byte currently held |
| ext_armed | output | 1 | Extension flag |
| res_valid | output | 1 | Result strobe, one cycle after an eligible issue |
| res_value | output | 16 | Effective 16-bit operand or target |

## Verification
The bench builds the block with its defaults: an 8-bit immediate, which gives a 16-bit result, and a jump bias of one.

At these widths, the 16-bit sums wrap in both directions:
- an armed index addition that overflows;
- an unarmed negative addition that goes below zero;
- a positive jump that crosses 0xFFFF.

Checks are placed on each of these boundaries. The directed sequences also cover:
- an extension consumed by a plain instruction and then ignored by the next load;
- a write and an issue in the same cycle.

// File: rtl/extpfx_pkg.sv
package extpfx_pkg;
  typedef enum logic [1:0] {
    CLS_PLAIN    = 2'b00,
    CLS_IDX_LOAD = 2'b01,
    CLS_IDX_ADD  = 2'b10,
    CLS_REL_JUMP = 2'b11
  } issue_cls_e;
endpackage

// File: rtl/extpfx_hold.sv
module extpfx_hold #(
  parameter int IMM_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IMM_W-1:0] wr_byte,
  input  logic             consume,
  output logic [IMM_W-1:0] hi_byte,
  output logic             armed
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_byte <= '0;
      armed   <= 1'b0;
    end else begin
      if (wr_en) begin
        hi_byte <= wr_byte;
      end
      if (wr_en) begin
        armed <= 1'b1;
      end else if (consume) begin
        armed <= 1'b0;
      end
    end
  end

  // R2: a write both stores the byte and arms the flag
  a_r2_write_arms: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (armed && hi_byte == $past(wr_byte)));

  // R4: an issue without a write always disarms
  a_r4_issue_disarms: assert property (@(posedge clk) disable iff (rst)
    (consume && !wr_en) |=> !armed);

  // R3: the byte survives everything except a write
  a_r3_byte_persists: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(hi_byte));
endmodule

// File: rtl/extpfx_operand.sv
module extpfx_operand
  import extpfx_pkg::*;
#(
  parameter int IMM_W     = 8,
  parameter int JUMP_BIAS = 1,
  localparam int OP_W     = 2 * IMM_W
) (
  input  logic             armed,
  input  logic [IMM_W-1:0] hi_byte,
  input  logic [IMM_W-1:0] imm,
  input  logic [OP_W-1:0]  base,
  input  issue_cls_e       cls,
  output logic [OP_W-1:0]  value
);
  logic [OP_W-1:0] wide_imm;
  logic [OP_W-1:0] load_val;
  logic [OP_W-1:0] add_val;
  logic [OP_W-1:0] jump_val;

  always_comb begin
    if (armed) begin
      wide_imm = {hi_byte, imm};
      load_val = {hi_byte, imm};
    end else begin
      wide_imm = {{IMM_W{imm[IMM_W-1]}}, imm};
      load_val = {base[OP_W-1:IMM_W], imm};
    end
  end

  assign add_val = base + wide_imm;

  generate
    if (JUMP_BIAS == 0) begin : g_nobias
      assign jump_val = add_val;
    end else begin : g_bias
      localparam logic [OP_W-1:0] BIAS = OP_W'(JUMP_BIAS);
      assign jump_val = add_val + BIAS;
    end
  endgenerate

  always_comb begin
    unique case (cls)
      CLS_IDX_LOAD: value = load_val;
      CLS_IDX_ADD:  value = add_val;
      CLS_REL_JUMP: value = jump_val;
      default:      value = {{IMM_W{1'b0}}, imm};
    endcase
  end
endmodule

// File: rtl/extpfx_result.sv
module extpfx_result #(
  parameter int OP_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [OP_W-1:0] next_value,
  output logic            valid,
  output logic [OP_W-1:0] value
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      value <= '0;
    end else begin
      valid <= load;
      if (load) begin
        value <= next_value;
      end
    end
  end

  // R10: the result register changes only on a load
  a_r10_value_holds: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(value));

  // R10: the strobe never lasts two cycles without a second load
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
    (valid && !load) |=> !valid);
endmodule

// File: rtl/ext_prefix_unit.sv
module ext_prefix_unit
  import extpfx_pkg::*;
#(
  parameter int IMM_W     = 8,
  parameter int JUMP_BIAS = 1,
  localparam int OP_W     = 2 * IMM_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_wr,
  input  logic [IMM_W-1:0] ext_wdata,
  input  logic             issue,
  input  logic [1:0]       issue_cls,
  input  logic [IMM_W-1:0] imm,
  input  logic [OP_W-1:0]  op_base,
  output logic [IMM_W-1:0] ext_byte,
  output logic             ext_armed,
  output logic             res_valid,
  output logic [OP_W-1:0]  res_value
);
  issue_cls_e      cls;
  logic            eligible;
  logic [OP_W-1:0] operand;

  assign cls      = issue_cls_e'(issue_cls);
  assign eligible = issue && (cls != CLS_PLAIN);

  extpfx_hold #(.IMM_W(IMM_W)) hold_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (ext_wr),
    .wr_byte (ext_wdata),
    .consume (issue),
    .hi_byte (ext_byte),
    .armed   (ext_armed)
  );

  extpfx_operand #(.IMM_W(IMM_W), .JUMP_BIAS(JUMP_BIAS)) operand_i (
    .armed   (ext_armed),
    .hi_byte (ext_byte),
    .imm     (imm),
    .base    (op_base),
    .cls     (cls),
    .value   (operand)
  );

  extpfx_result #(.OP_W(OP_W)) result_i (
    .clk        (clk),
    .rst        (rst),
    .load       (eligible),
    .next_value (operand),
    .valid      (res_valid),
    .value      (res_value)
  );

  // R8: a plain issue never raises the result strobe
  a_r8_plain_silent: assert property (@(posedge clk) disable iff (rst)
    (issue && cls == CLS_PLAIN) |=> !res_valid);

  // R5: an armed low-byte load yields the held byte on top of the immediate
  a_r5_armed_load: assert property (@(posedge clk) disable iff (rst)
    (issue && cls == CLS_IDX_LOAD && ext_armed)
      |=> (res_value == {$past(ext_byte), $past(imm)}));

  // R9: a write issued together with an instruction still leaves the flag armed
  a_r9_write_wins_flag: assert property (@(posedge clk) disable iff (rst)
    (issue && ext_wr) |=> ext_armed);
endmodule

// File: tb/ext_prefix_unit_tb_top.sv
module ext_prefix_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        ext_wr;
  logic [7:0]  ext_wdata;
  logic        issue;
  logic [1:0]  issue_cls;
  logic [7:0]  imm;
  logic [15:0] op_base;
  logic [7:0]  ext_byte;
  logic        ext_armed;
  logic        res_valid;
  logic [15:0] res_value;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  ext_prefix_unit dut_i (
    .clk       (clk),
    .rst       (rst),
    .ext_wr    (ext_wr),
    .ext_wdata (ext_wdata),
    .issue     (issue),
    .issue_cls (issue_cls),
    .imm       (imm),
    .op_base   (op_base),
    .ext_byte  (ext_byte),
    .ext_armed (ext_armed),
    .res_valid (res_valid),
    .res_value (res_value)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    ext_wr = 1'b0; issue = 1'b0;
  endtask

  task automatic write_ext(input logic [7:0] b);
    ext_wr = 1'b1; ext_wdata = b; issue = 1'b0;
    step();
    idle();
  endtask

  task automatic issue_op(input logic [1:0] c, input logic [7:0] im, input logic [15:0] base);
    issue = 1'b1; issue_cls = c; imm = im; op_base = base; ext_wr = 1'b0;
    step();
    idle();
  endtask

  task automatic t_reset();
    check("R1 ext_byte", 32'(ext_byte), 0);
    check("R1 ext_armed", 32'(ext_armed), 0);
    check("R1 res_valid", 32'(res_valid), 0);
    check("R1 res_value", 32'(res_value), 0);
  endtask

  task automatic t_index_load();
    write_ext(8'h15);
    check("R2 byte", 32'(ext_byte), 32'h15);
    check("R2 armed", 32'(ext_armed), 1);
    issue_op(2'b01, 8'h7D, 16'hAAAA);
    check("R5 armed load", 32'(res_value), 32'h157D);
    check("R10 valid", 32'(res_valid), 1);
    check("R4 disarmed", 32'(ext_armed), 0);
    check("R3 byte kept", 32'(ext_byte), 32'h15);
    issue_op(2'b01, 8'h42, 16'hAB00);
    check("R5 plain load", 32'(res_value), 32'hAB42);
    step();
    check("R10 valid drop", 32'(res_valid), 0);
    check("R10 value held", 32'(res_value), 32'hAB42);
  endtask

  task automatic t_index_add();
    write_ext(8'hB8);
    issue_op(2'b10, 8'h10, 16'h7F00);
    check("R6 armed add wrap", 32'(res_value), 32'h3710);
    issue_op(2'b10, 8'hF0, 16'h0005);
    check("R6 plain negative add", 32'(res_value), 32'hFFF5);
  endtask

  task automatic t_rel_jump();
    write_ext(8'h01);
    issue_op(2'b11, 8'h80, 16'h1000);
    check("R7 armed jump", 32'(res_value), 32'h1181);
    issue_op(2'b11, 8'h80, 16'h1000);
    check("R7 plain backward", 32'(res_value), 32'h0F81);
    issue_op(2'b11, 8'h7F, 16'hFFF0);
    check("R7 plain wrap", 32'(res_value), 32'h0070);
  endtask

  task automatic t_plain_consumes();
    write_ext(8'h22);
    issue_op(2'b00, 8'h33, 16'h1234);
    check("R8 no valid", 32'(res_valid), 0);
    check("R8 value held", 32'(res_value), 32'h0070);
    check("R4 plain disarms", 32'(ext_armed), 0);
    issue_op(2'b01, 8'h44, 16'h5500);
    check("R4 later load unextended", 32'(res_value), 32'h5544);
  endtask

  task automatic t_simultaneous();
    write_ext(8'h99);
    ext_wr = 1'b1; ext_wdata = 8'h66;
    issue = 1'b1; issue_cls = 2'b01; imm = 8'h01; op_base = 16'h0000;
    step();
    idle();
    check("R9 old byte used", 32'(res_value), 32'h9901);
    check("R9 armed after", 32'(ext_armed), 1);
    check("R9 new byte", 32'(ext_byte), 32'h66);
    issue_op(2'b01, 8'h02, 16'h0000);
    check("R9 new byte used", 32'(res_value), 32'h6602);
  endtask

  initial begin
    rst = 1'b1; ext_wr = 1'b0; ext_wdata = '0; issue = 1'b0;
    issue_cls = '0; imm = '0; op_base = '0;
    step();
    step();
    t_reset();
    rst = 1'b0;
    step();
    t_reset();
    t_index_load();
    t_index_add();
    t_rel_jump();
    t_plain_consumes();
    t_simultaneous();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
    end
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end
endmodule